// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a binary counter that can count in either direction. It is built from identical stages, each `WIDTH` bits wide, that are chained into one counter of `STAGES * WIDTH` bits. Each stage has its own increment enable and its own decrement enable. Each stage also has a synchronous parallel load and an asynchronous clear. The clear and the load have priority over counting.

For each direction, a stage computes two combinational outputs:
- a terminal-count flag, which shows that the stage is at its extreme value;
- a cascade enable, which is that flag gated by the stage's own enable for that direction.

The cascade enables of one stage drive the enables of the next stage. The clock, load and clear are shared by all stages. As a result the higher stages advance only when every lower stage is about to wrap. The terminal counts of the whole chain are the AND of the terminal counts of all stages.

In normal use only one direction enable is high at a time. If both are high at the same edge, the stage that receives them holds its value.

Top module: `udcnt_chain`

## Requirements
- R1: While `clr` is high, independent of the clock and of all other inputs: `count` is 0, `tcUp` is 0, `tcDn` is 1, `ceoUp` is 0 and `ceoDn` is 1. Raising `clr` between clock edges zeroes `count` at once.
- R2: At a rising edge with `clr` low and `load` high, `count` takes the value of `loadData`, whatever `upEn` and `downEn` are.
- R3: At a rising edge with `clr` and `load` low, `upEn` high and `downEn` low, `count` increments by one modulo 2^(STAGES*WIDTH). The maximum value wraps to 0.
- R4: At a rising edge with `clr` and `load` low, `downEn` high and `upEn` low, `count` decrements by one modulo 2^(STAGES*WIDTH). A value of 0 wraps to the maximum value.
- R5: At a rising edge with `clr`, `load`, `upEn` and `downEn` all low, `count` keeps its value.
- R6: At a rising edge with `load` low and both `upEn` and `downEn` high, the lowest stage (bits WIDTH-1:0) keeps its value. If that stage is neither all ones nor all zeros, the whole `count` keeps its value.
- R7: With `clr` low, `tcUp` is 1 exactly when every bit of `count` is 1, and `tcDn` is 1 exactly when every bit of `count` is 0. Neither flag depends on `upEn` or `downEn`.
- R8: With `clr` low, `ceoUp` is 1 exactly when every bit of `count` is 1 and `upEn` is 1. `ceoDn` is 1 exactly when every bit of `count` is 0 and `downEn` is 1. Both follow their inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| load | input | 1 | Synchronous parallel load, active high |
| loadData | input | STAGES*WIDTH | Value taken on a load |
| upEn | input | 1 | Increment enable for the lowest stage |
| downEn | input | 1 | Decrement enable for the lowest stage |
| count | output | STAGES*WIDTH | Current count, lowest stage in the low bits |
| tcUp | output | 1 | All count bits are one |
| tcDn | output | 1 | All count bits are zero |
| ceoUp | output | 1 | Up cascade enable out of the top stage |
| ceoDn | output | 1 | Down cascade enable out of the top stage |

## Verification
A stage register holding a wrong value shows on `count` and on the terminal-count flags at the first sample after the faulty edge. A wrong cascade decision shows up differently: it stays hidden until a lower stage passes its wrap point. At that moment a higher byte either fails to move or moves one step early. The bench therefore drives the count through the all-ones and all-zeros boundaries of each byte and of the full width. It compares every cycle against a wide reference counter, so a corrupted stage is reported within one clock of the edge that exposes it.

// File: rtl/udcnt_pkg.sv
package udcnt_pkg;

  // Strobes from a stage's control half to its datapath half.
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } udcnt_strobe_t;

endpackage

// File: rtl/udcnt_ctrl.sv
module udcnt_ctrl
  import udcnt_pkg::*;
(
  input  logic          clr,
  input  logic          load,
  input  logic          upEn,
  input  logic          downEn,
  input  logic          allOnes,
  input  logic          allZero,
  output udcnt_strobe_t strb,
  output logic          ceoUp,
  output logic          ceoDn
);

  // A load overrides counting. When both enables are high, the stage holds.
  always_comb begin
    strb.load = load;
    strb.inc  = !load && upEn && !downEn;
    strb.dec  = !load && downEn && !upEn;
  end

  // The cascade enables are forced to their cleared levels while clr is high.
  assign ceoUp = allOnes && upEn && !clr;
  assign ceoDn = (allZero && downEn) || clr;

endmodule

// File: rtl/udcnt_datapath.sv
module udcnt_datapath
  import udcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  udcnt_strobe_t    strb,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] q,
  output logic             allOnes,
  output logic             allZero
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)            q <= '0;
    else if (strb.load) q <= loadData;
    else if (strb.inc)  q <= q + ONE;
    else if (strb.dec)  q <= q - ONE;
  end

  assign allOnes = &q;
  assign allZero = ~|q;

endmodule

// File: rtl/udcnt_stage.sv
module udcnt_stage
  import udcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] loadData,
  input  logic             upEn,
  input  logic             downEn,
  output logic [WIDTH-1:0] q,
  output logic             tcUp,
  output logic             tcDn,
  output logic             ceoUp,
  output logic             ceoDn
);

  udcnt_strobe_t strb;
  logic          allOnes;
  logic          allZero;

  udcnt_ctrl u_ctrl (
    .clr     (clr),
    .load    (load),
    .upEn    (upEn),
    .downEn  (downEn),
    .allOnes (allOnes),
    .allZero (allZero),
    .strb    (strb),
    .ceoUp   (ceoUp),
    .ceoDn   (ceoDn)
  );

  udcnt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .clr      (clr),
    .strb     (strb),
    .loadData (loadData),
    .q        (q),
    .allOnes  (allOnes),
    .allZero  (allZero)
  );

  assign tcUp = allOnes;
  assign tcDn = allZero;

endmodule

// File: rtl/udcnt_chain.sv
module udcnt_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 3
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      load,
  input  logic [STAGES*WIDTH-1:0]   loadData,
  input  logic                      upEn,
  input  logic                      downEn,
  output logic [STAGES*WIDTH-1:0]   count,
  output logic                      tcUp,
  output logic                      tcDn,
  output logic                      ceoUp,
  output logic                      ceoDn
);

  localparam int TOTAL_W = STAGES * WIDTH;

  logic [STAGES:0]   upLink;
  logic [STAGES:0]   dnLink;
  logic [STAGES-1:0] tcUpVec;
  logic [STAGES-1:0] tcDnVec;

  assign upLink[0] = upEn;
  assign dnLink[0] = downEn;

  // Each stage's cascade enables feed the enables of the stage above it.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    udcnt_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .clr      (clr),
      .load     (load),
      .loadData (loadData[s*WIDTH +: WIDTH]),
      .upEn     (upLink[s]),
      .downEn   (dnLink[s]),
      .q        (count[s*WIDTH +: WIDTH]),
      .tcUp     (tcUpVec[s]),
      .tcDn     (tcDnVec[s]),
      .ceoUp    (upLink[s+1]),
      .ceoDn    (dnLink[s+1])
    );
  end

  assign tcUp  = &tcUpVec;
  assign tcDn  = &tcDnVec;
  assign ceoUp = upLink[STAGES];
  assign ceoDn = dnLink[STAGES];

  initial begin
    if (TOTAL_W < 1) $error("udcnt_chain: empty counter");
  end

endmodule

// File: rtl/udcnt_chain_chk.sv
module udcnt_chain_chk #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 3
) (
  input logic                    clk,
  input logic                    clr,
  input logic                    load,
  input logic [STAGES*WIDTH-1:0] loadData,
  input logic                    upEn,
  input logic                    downEn,
  input logic [STAGES*WIDTH-1:0] count,
  input logic                    tcUp,
  input logic                    tcDn,
  input logic                    ceoUp,
  input logic                    ceoDn
);

  localparam int TOTAL_W = STAGES * WIDTH;
  localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

  // R1: the outputs show the cleared state while clr is high.
  always @(negedge clk) begin
    if (clr) begin
      a_r1_clear_state: assert (count == '0 && !tcUp && tcDn && !ceoUp && ceoDn)
        else $error("R1 cleared state violated");
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (clr)
    load |=> count == $past(loadData));

  a_r3_increment: assert property (@(posedge clk) disable iff (clr)
    (!load && upEn && !downEn) |=> count == $past(count) + ONE);

  a_r4_decrement: assert property (@(posedge clk) disable iff (clr)
    (!load && downEn && !upEn) |=> count == $past(count) - ONE);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (clr)
    (!load && !upEn && !downEn) |=> $stable(count));

  a_r6_conflict_hold: assert property (@(posedge clk) disable iff (clr)
    (!load && upEn && downEn) |=> count[WIDTH-1:0] == $past(count[WIDTH-1:0]));

  a_r7_terminal: assert property (@(posedge clk) disable iff (clr)
    (tcUp == (&count)) && (tcDn == (count == '0)));

  a_r8_cascade: assert property (@(posedge clk) disable iff (clr)
    (ceoUp == (upEn && (&count))) && (ceoDn == (downEn && count == '0)));

endmodule

bind udcnt_chain udcnt_chain_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .load     (load),
  .loadData (loadData),
  .upEn     (upEn),
  .downEn   (downEn),
  .count    (count),
  .tcUp     (tcUp),
  .tcDn     (tcDn),
  .ceoUp    (ceoUp),
  .ceoDn    (ceoDn)
);

// File: tb/tb_udcnt_chain.sv
`timescale 1ns/1ps
module tb_udcnt_chain;

  localparam int WIDTH  = 8;
  localparam int STAGES = 3;
  localparam int TW     = WIDTH * STAGES;
  localparam logic [TW-1:0] MAXV = {TW{1'b1}};

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          load = 1'b0;
  logic [TW-1:0] loadData = '0;
  logic          upEn = 1'b0;
  logic          downEn = 1'b0;
  logic [TW-1:0] count;
  logic          tcUp, tcDn, ceoUp, ceoDn;

  int checks = 0;
  int failures = 0;
  logic [TW-1:0] model = '0;

  always #10 clk = ~clk;

  udcnt_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) dut (
    .clk(clk), .clr(clr), .load(load), .loadData(loadData),
    .upEn(upEn), .downEn(downEn), .count(count),
    .tcUp(tcUp), .tcDn(tcDn), .ceoUp(ceoUp), .ceoDn(ceoDn)
  );

  function automatic logic [TW-1:0] nextVal(logic [TW-1:0] cur, logic ld,
                                            logic [TW-1:0] d, logic up, logic dn);
    if (ld)            return d;
    else if (up && !dn) return cur + 1'b1;
    else if (dn && !up) return cur - 1'b1;
    else               return cur;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare count, terminal counts and cascade enables with the model.
  task automatic chkAll(string tag);
    chk(tag, 32'(count), 32'(model));
    chk("R7 tcUp", 32'(tcUp), 32'(model == MAXV));
    chk("R7 tcDn", 32'(tcDn), 32'(model == '0));
    chk("R8 ceoUp", 32'(ceoUp), 32'(upEn && model == MAXV));
    chk("R8 ceoDn", 32'(ceoDn), 32'(downEn && model == '0));
  endtask

  // Called at a negedge: drive the inputs, let one rising edge pass, then check.
  task automatic step(logic ld, logic [TW-1:0] d, logic up, logic dn, string tag);
    load = ld; loadData = d; upEn = up; downEn = dn;
    model = nextVal(model, ld, d, up, dn);
    @(posedge clk); #5;
    chkAll(tag);
    @(negedge clk);
  endtask

  task automatic doClearCheck(string tag);
    chk({tag, " count"}, 32'(count), 32'd0);
    chk({tag, " tcUp"}, 32'(tcUp), 32'd0);
    chk({tag, " tcDn"}, 32'(tcDn), 32'd1);
    chk({tag, " ceoUp"}, 32'(ceoUp), 32'd0);
    chk({tag, " ceoDn"}, 32'(ceoDn), 32'd1);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1C0DE5));

    // R1: clear state, with the other inputs active and the clock running.
    load = 1'b1; loadData = 24'hA5A5A5; upEn = 1'b1; downEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    doClearCheck("R1 clr+up");
    upEn = 1'b0; downEn = 1'b0; #1;
    doClearCheck("R1 clr idle");
    load = 1'b0;
    clr = 1'b0;
    model = '0;
    #1 chkAll("R5 after release");

    // R5: idle edges keep the zero value.
    step(1'b0, '0, 1'b0, 1'b0, "R5 idle at zero");

    // R4: from zero, count down and wrap to the maximum.
    step(1'b0, '0, 1'b0, 1'b1, "R4 wrap down");
    // R8 / R7: at all ones with upEn low, tcUp is 1 but ceoUp is 0.
    step(1'b0, '0, 1'b0, 1'b0, "R5 hold at max");
    // R3: wrap up from the maximum to zero.
    step(1'b0, '0, 1'b1, 1'b0, "R3 wrap up");

    // R2: a load overrides both enables.
    step(1'b1, 24'h00FFFF, 1'b1, 1'b1, "R2 load both enables");
    step(1'b0, '0, 1'b1, 1'b0, "R3 byte carry");
    step(1'b1, 24'h010000, 1'b0, 1'b1, "R2 load with down");
    step(1'b0, '0, 1'b0, 1'b1, "R4 byte borrow");

    // R6: both enables, low byte away from the boundaries -> whole count holds.
    step(1'b1, 24'h123456, 1'b0, 1'b0, "R2 load");
    step(1'b0, '0, 1'b1, 1'b1, "R6 conflict hold");
    // R6: low byte all ones -> low byte holds, upper bytes follow the up cascade.
    step(1'b1, 24'h1234FF, 1'b0, 1'b0, "R2 load");
    load = 1'b0; upEn = 1'b1; downEn = 1'b1;
    @(posedge clk); #5;
    chk("R6 low byte holds", 32'(count[WIDTH-1:0]), 32'hFF);
    chk("R6 upper cascade", 32'(count[TW-1:WIDTH]), 32'h1235);
    model = count;
    @(negedge clk);

    // R3/R4/R2/R5: random mix, never both enables at once.
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(99);
      logic [TW-1:0] d;
      d = TW'($urandom());
      if (r < 3) d = MAXV - TW'($urandom_range(2));
      else if (r < 6) d = TW'($urandom_range(2));
      if (r < 10)      step(1'b1, d, r[0], !r[0], "R2 random load");
      else if (r < 55) step(1'b0, d, 1'b1, 1'b0, "R3 random up");
      else if (r < 92) step(1'b0, d, 1'b0, 1'b1, "R4 random down");
      else             step(1'b0, d, 1'b0, 1'b0, "R5 random idle");
    end

    // R1: asynchronous clear between edges.
    step(1'b1, 24'h0F0F0F, 1'b0, 1'b0, "R2 load");
    upEn = 1'b1;
    @(posedge clk); #5;
    clr = 1'b1; #2;
    doClearCheck("R1 async");
    @(negedge clk);
    clr = 1'b0; upEn = 1'b0;
    model = '0;
    #1 chkAll("R1 released");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule